// File: doc/BRIEF.md
# Paged Configuration Memory with Block Write Locks

This block holds 512 bytes of module configuration data in a register array. The array is split into two pages of 256 bytes, and each page holds two blocks of 128 bytes. The block keeps a page pointer so that a client using plain 8-bit addresses reaches either page without changing its addressing. A parallel command port replaces the usual serial bus. One command is sampled on each clock edge where `cmd_valid` is high.

Each of the four 128-byte blocks has its own write lock. A lock can be set only while the high-voltage qualifier is present. A clear needs the same qualifier and removes all four locks together. A write that lands in a locked block leaves the byte untouched and pulses `wr_reject`. A lock command without the qualifier changes nothing and pulses `cmd_reject`. Reads ignore the locks. After reset the lock bits take their values from `lock_init`, which stands in for retained state.

The controller is a small state machine. Reset enters `ST_IDLE`. A sampled command moves the machine into the state that performs it on the next edge: READ to `ST_READ`, WRITE to `ST_WRITE`, either page command to `ST_PAGE`, set-lock with the qualifier to `ST_SETLK`, and clear-lock with the qualifier to `ST_CLRLK`. A lock command without the qualifier goes to `ST_DENY`. NOP, the reserved code, or `cmd_valid` low goes to `ST_IDLE`. Every state leaves through the same decision on the next command, so back-to-back commands run one per cycle.

Top module: `spd_wp_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `page_sel` is 0, `lock_state` equals `lock_init`, and `rdata_valid`, `wr_reject` and `cmd_reject` are 0.
- R2: The opcode codes are NOP=0, READ=1, WRITE=2, PAGE0=3, PAGE1=4, SETLK=5, CLRLK=6, and 7 is reserved and acts as NOP. A WRITE stores `cmd_wdata` at byte {page_sel, cmd_addr}. A READ returns that byte on `rdata` with `rdata_valid` high for one cycle.
- R3: PAGE0 sets `page_sel` to 0 and PAGE1 sets it to 1. The same 8-bit address on different pages names two separate bytes.
- R4: The lock bit that guards a write is index {page_sel, cmd_addr[7]}. A WRITE into a locked block leaves the byte unchanged and raises `wr_reject` for one cycle.
- R5: SETLK with `hv_present` high sets lock bit `cmd_addr[1:0]` and leaves the other three unchanged.
- R6: CLRLK with `hv_present` high clears all four lock bits at once. After that, writes to formerly locked blocks succeed.
- R7: SETLK or CLRLK with `hv_present` low leaves `lock_state` unchanged and raises `cmd_reject` for one cycle.
- R8: A READ returns the stored byte whatever the lock bits are.
- R9: A lock can be set again after a clear, and it then blocks writes again.
- R10: Every result appears one clock edge after the edge that sampled the command. One command may be sampled on every edge. At most one of `rdata_valid`, `wr_reject` and `cmd_reject` is high at a time. A command presented with `cmd_valid` low, or a NOP, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_addr | input | 8 | In-page byte address; bits [1:0] pick the block for SETLK |
| cmd_wdata | input | 8 | Write data |
| hv_present | input | 1 | High-voltage qualifier for lock commands |
| lock_init | input | 4 | Lock values loaded at reset |
| rdata | output | 8 | Read data; holds its last value between reads |
| rdata_valid | output | 1 | One-cycle pulse with read data |
| wr_reject | output | 1 | One-cycle pulse: write hit a locked block |
| cmd_reject | output | 1 | One-cycle pulse: lock command lacked the qualifier |
| page_sel | output | 1 | Active page |
| lock_state | output | 4 | Current lock bit per block |

## Verification
The edge that samples a command only moves it into the state register. Memory, page pointer, lock bits and the three result pulses all change on the edge after that. So every result is due one full cycle after the sampling edge. The bench drives inputs on a falling edge and drops `cmd_valid` on the next falling edge. It reads all outputs on the falling edge after that, which puts every sample half a cycle clear of the edge that produced it. One directed test issues a write and a read on consecutive edges. It samples the write result and then the read result one falling edge apart, so the one-command-per-cycle path is checked with the same spacing.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_PAGE0 = 3'd3,
        OP_PAGE1 = 3'd4,
        OP_SETLK = 3'd5,
        OP_CLRLK = 3'd6,
        OP_RSVD  = 3'd7
    } spd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_PAGE,
        ST_SETLK,
        ST_CLRLK,
        ST_DENY
    } spd_state_e;

endpackage

// File: rtl/spd_store.sv
module spd_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/spd_lock_bank.sv
module spd_lock_bank #(
    parameter int NUM_BLKS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BLKS-1:0]         init,
    input  logic                        set_en,
    input  logic [$clog2(NUM_BLKS)-1:0] set_idx,
    input  logic                        clr_en,
    output logic [NUM_BLKS-1:0]         locks
);
    for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                locks[b] <= init[b];
            end else if (clr_en) begin
                locks[b] <= 1'b0;
            end else if (set_en && (set_idx == b)) begin
                locks[b] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spd_cmd_fsm.sv
module spd_cmd_fsm
    import spd_wp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              hv_present,
    input  logic              lock_hit,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              lat_page_hi,
    output logic              do_read,
    output logic              do_write,
    output logic              do_page,
    output logic              do_set,
    output logic              do_clr,
    output logic              rvalid_q,
    output logic              wrej_q,
    output logic              crej_q
);
    spd_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (cmd_valid) begin
            unique case (spd_op_e'(cmd_op))
                OP_READ:  state_d = ST_READ;
                OP_WRITE: state_d = ST_WRITE;
                OP_PAGE0,
                OP_PAGE1: state_d = ST_PAGE;
                OP_SETLK: state_d = hv_present ? ST_SETLK : ST_DENY;
                OP_CLRLK: state_d = hv_present ? ST_CLRLK : ST_DENY;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register with the command fields it carries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lat_addr    <= '0;
            lat_wdata   <= '0;
            lat_page_hi <= 1'b0;
        end else begin
            state_q     <= state_d;
            lat_addr    <= cmd_addr;
            lat_wdata   <= cmd_wdata;
            lat_page_hi <= (cmd_op == OP_PAGE1);
        end
    end

    // Per-state controls to the datapath
    always_comb begin
        do_read  = 1'b0;
        do_write = 1'b0;
        do_page  = 1'b0;
        do_set   = 1'b0;
        do_clr   = 1'b0;
        unique case (state_q)
            ST_READ:  do_read  = 1'b1;
            ST_WRITE: do_write = !lock_hit;
            ST_PAGE:  do_page  = 1'b1;
            ST_SETLK: do_set   = 1'b1;
            ST_CLRLK: do_clr   = 1'b1;
            default:  ;
        endcase
    end

    // Registered result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            wrej_q   <= 1'b0;
            crej_q   <= 1'b0;
        end else begin
            rvalid_q <= (state_q == ST_READ);
            wrej_q   <= (state_q == ST_WRITE) && lock_hit;
            crej_q   <= (state_q == ST_DENY);
        end
    end
endmodule

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl
    import spd_wp_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int NUM_PAGES     = 2,
    parameter int BLKS_PER_PAGE = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cmd_valid,
    input  logic [2:0]                             cmd_op,
    input  logic [ADDR_W-1:0]                      cmd_addr,
    input  logic [DATA_W-1:0]                      cmd_wdata,
    input  logic                                   hv_present,
    input  logic [NUM_PAGES*BLKS_PER_PAGE-1:0]     lock_init,
    output logic [DATA_W-1:0]                      rdata,
    output logic                                   rdata_valid,
    output logic                                   wr_reject,
    output logic                                   cmd_reject,
    output logic [$clog2(NUM_PAGES)-1:0]           page_sel,
    output logic [NUM_PAGES*BLKS_PER_PAGE-1:0]     lock_state
);
    localparam int NUM_BLKS = NUM_PAGES * BLKS_PER_PAGE;
    localparam int PAGE_W   = $clog2(NUM_PAGES);
    localparam int BIP_W    = $clog2(BLKS_PER_PAGE);
    localparam int BLK_W    = $clog2(NUM_BLKS);
    localparam int DEPTH    = NUM_PAGES * (2 ** ADDR_W);

    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_page_hi;
    logic              do_read, do_write, do_page, do_set, do_clr;
    logic [BLK_W-1:0]  hit_idx;
    logic              lock_hit;
    logic [PAGE_W-1:0] page_q;

    assign hit_idx  = {page_q, lat_addr[ADDR_W-1 -: BIP_W]};
    assign lock_hit = lock_state[hit_idx];

    spd_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .hv_present  (hv_present),
        .lock_hit    (lock_hit),
        .lat_addr    (lat_addr),
        .lat_wdata   (lat_wdata),
        .lat_page_hi (lat_page_hi),
        .do_read     (do_read),
        .do_write    (do_write),
        .do_page     (do_page),
        .do_set      (do_set),
        .do_clr      (do_clr),
        .rvalid_q    (rdata_valid),
        .wrej_q      (wr_reject),
        .crej_q      (cmd_reject)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (do_page) begin
            page_q <= PAGE_W'(lat_page_hi);
        end
    end
    assign page_sel = page_q;

    spd_lock_bank #(.NUM_BLKS(NUM_BLKS)) u_locks (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (lock_init),
        .set_en  (do_set),
        .set_idx (lat_addr[BLK_W-1:0]),
        .clr_en  (do_clr),
        .locks   (lock_state)
    );

    spd_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_write),
        .re    (do_read),
        .addr  ({page_q, lat_addr}),
        .wdata (lat_wdata),
        .rdata (rdata)
    );
endmodule

// File: rtl/spd_wp_ctrl_chk.sv
module spd_wp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       hv_present,
    input logic       rdata_valid,
    input logic       wr_reject,
    input logic       cmd_reject,
    input logic       page_sel,
    input logic [3:0] lock_state
);
    AST_READ_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> ($past(cmd_valid, 2) && $past(cmd_op, 2) == 3'd1)); // R2

    AST_PAGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (page_sel != $past(page_sel)) |->
        ($past(cmd_valid, 2) && ($past(cmd_op, 2) == 3'd3 || $past(cmd_op, 2) == 3'd4))); // R3

    AST_WREJ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> ($past(cmd_valid, 2) && $past(cmd_op, 2) == 3'd2)); // R4

    AST_LOCK_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state != $past(lock_state)) |-> $past(hv_present, 2)); // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid, 2) && $past(cmd_op, 2) == 3'd6 && $past(hv_present, 2))
        |-> (lock_state == 4'b0000)); // R6

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rdata_valid, wr_reject, cmd_reject})); // R10
endmodule

bind spd_wp_ctrl spd_wp_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .hv_present  (hv_present),
    .rdata_valid (rdata_valid),
    .wr_reject   (wr_reject),
    .cmd_reject  (cmd_reject),
    .page_sel    (page_sel),
    .lock_state  (lock_state)
);

// File: tb/spd_wp_ctrl_test.sv
module spd_wp_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_addr = 8'h00;
    logic [7:0] cmd_wdata = 8'h00;
    logic       hv_present = 1'b0;
    logic [3:0] lock_init = 4'b0000;
    logic [7:0] rdata;
    logic       rdata_valid, wr_reject, cmd_reject, page_sel;
    logic [3:0] lock_state;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    spd_wp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .hv_present(hv_present),
        .lock_init(lock_init), .rdata(rdata), .rdata_valid(rdata_valid),
        .wr_reject(wr_reject), .cmd_reject(cmd_reject), .page_sel(page_sel),
        .lock_state(lock_state)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] addr;
        logic [7:0] wd;
        logic       hv;
        logic       rv;
        logic [7:0] rd;
        logic       wrej;
        logic       crej;
        logic [3:0] lk;
        logic       pg;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 8'h10, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd2},  // R2 write p0
        '{3'd1, 8'h10, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd2},  // R2 read p0
        '{3'd4, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b1, 4'd3},  // R3 page 1
        '{3'd2, 8'h10, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b1, 4'd3},  // R3
        '{3'd1, 8'h10, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 4'b0000, 1'b1, 4'd3},  // R3
        '{3'd3, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd3},  // R3 page 0
        '{3'd1, 8'h10, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd3},  // R3
        '{3'd5, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0001, 1'b0, 4'd5},  // R5 lock blk0
        '{3'd2, 8'h10, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'b0001, 1'b0, 4'd4},  // R4 blocked
        '{3'd1, 8'h10, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 4'b0001, 1'b0, 4'd8},  // R8
        '{3'd2, 8'h90, 8'h77, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0001, 1'b0, 4'd4},  // R4 blk1 open
        '{3'd1, 8'h90, 8'h00, 1'b0, 1'b1, 8'h77, 1'b0, 1'b0, 4'b0001, 1'b0, 4'd4},  // R4
        '{3'd5, 8'h03, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'b0001, 1'b0, 4'd7},  // R7 no hv
        '{3'd5, 8'h03, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1001, 1'b0, 4'd5},  // R5 lock blk3
        '{3'd4, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1001, 1'b1, 4'd3},  // R3
        '{3'd2, 8'h90, 8'h11, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'b1001, 1'b1, 4'd4},  // R4 blk3
        '{3'd2, 8'h20, 8'h22, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1001, 1'b1, 4'd4},  // R4 blk2
        '{3'd1, 8'h20, 8'h00, 1'b0, 1'b1, 8'h22, 1'b0, 1'b0, 4'b1001, 1'b1, 4'd4},  // R4
        '{3'd6, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'b1001, 1'b1, 4'd7},  // R7 clr no hv
        '{3'd6, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b1, 4'd6},  // R6 clear
        '{3'd2, 8'h90, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b1, 4'd6},  // R6
        '{3'd1, 8'h90, 8'h00, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 4'b0000, 1'b1, 4'd6},  // R6
        '{3'd5, 8'h02, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0100, 1'b1, 4'd9},  // R9 relock
        '{3'd2, 8'h20, 8'h55, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'b0100, 1'b1, 4'd9},  // R9
        '{3'd1, 8'h20, 8'h00, 1'b0, 1'b1, 8'h22, 1'b0, 1'b0, 4'b0100, 1'b1, 4'd8},  // R8
        '{3'd0, 8'h20, 8'h99, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0100, 1'b1, 4'd10}, // R10 NOP
        '{3'd7, 8'h20, 8'h99, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0100, 1'b1, 4'd10}  // R10 reserved
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_outs(input string req, input logic rv, input logic [7:0] rd,
                            input logic wrej, input logic crej, input logic [3:0] lk, input logic pg);
        chk(req, "rdata_valid", {7'd0, rdata_valid}, {7'd0, rv});
        if (rv) chk(req, "rdata", rdata, rd);
        chk(req, "wr_reject", {7'd0, wr_reject}, {7'd0, wrej});
        chk(req, "cmd_reject", {7'd0, cmd_reject}, {7'd0, crej});
        chk(req, "lock_state", {4'd0, lock_state}, {4'd0, lk});
        chk(req, "page_sel", {7'd0, page_sel}, {7'd0, pg});
    endtask

    // Drive on a falling edge, drop valid on the next one, sample on the one after
    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d, input logic hv);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; hv_present = hv;
        @(negedge clk);
        cmd_valid = 1'b0; hv_present = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] init);
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; lock_init = init;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs during reset
        repeat (2) @(negedge clk);
        chk_outs("R1", 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R1", 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].hv);
            chk_outs($sformatf("R%0d", VECS[i].req), VECS[i].rv, VECS[i].rd,
                     VECS[i].wrej, VECS[i].crej, VECS[i].lk, VECS[i].pg);
        end

        // R10: a write presented with cmd_valid low changes nothing
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd2; cmd_addr = 8'h90; cmd_wdata = 8'hEE;
        repeat (2) @(negedge clk);
        chk_outs("R10", 1'b0, 8'h00, 1'b0, 1'b0, 4'b0100, 1'b1);
        issue(3'd1, 8'h90, 8'h00, 1'b0);
        chk_outs("R10", 1'b1, 8'h11, 1'b0, 1'b0, 4'b0100, 1'b1);

        // R10: write then read on consecutive edges
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = 8'hC4; cmd_wdata = 8'h6B;
        @(negedge clk);
        cmd_op = 3'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_outs("R10", 1'b0, 8'h00, 1'b0, 1'b0, 4'b0100, 1'b1);
        @(negedge clk);
        chk_outs("R10", 1'b1, 8'h6B, 1'b0, 1'b0, 4'b0100, 1'b1);

        // R1: reset loads retained locks and returns to page 0
        do_reset(4'b1010);
        chk_outs("R1", 1'b0, 8'h00, 1'b0, 1'b0, 4'b1010, 1'b0);
        // R4: block 1 locked from reset, block 0 open
        issue(3'd2, 8'h85, 8'h42, 1'b0);
        chk_outs("R4", 1'b0, 8'h00, 1'b1, 1'b0, 4'b1010, 1'b0);
        issue(3'd2, 8'h05, 8'h43, 1'b0);
        chk_outs("R4", 1'b0, 8'h00, 1'b0, 1'b0, 4'b1010, 1'b0);
        issue(3'd1, 8'h05, 8'h00, 1'b0);
        chk_outs("R8", 1'b1, 8'h43, 1'b0, 1'b0, 4'b1010, 1'b0);
        // R5: setting an already locked bit keeps the others
        issue(3'd5, 8'h01, 8'h00, 1'b1);
        chk_outs("R5", 1'b0, 8'h00, 1'b0, 1'b0, 4'b1010, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule